// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block owns the program counter of a 32-bit, word-aligned instruction fetch path. On every rising clock edge it chooses the address of the next instruction from the instruction word currently fetched. Plain instructions step to the following word. The two conditional branches step by a signed word offset measured from the address after the branch. The unconditional jump moves to an absolute target inside the current 256 MB region.

The result of comparing the two register operands is computed outside this block and arrives as a single equality input. A stall input freezes the counter, and a synchronous reset sends it to the start of the program text. The block also drives the address of the following word, which the surrounding pipeline uses as a link or return value.

Top module: `npc_unit`

## Requirements
- R1: When `rst` is high at a rising edge, `pc` becomes 0x00400000 after that edge, whatever the values of `stall` and `instr`.
- R2: When `rst` is low and `stall` is high at a rising edge, `pc` keeps its value across that edge.
- R3: `pc_plus4` always equals `pc` + 4, modulo 2^32, with no clock delay.
- R4: The opcode is `instr[31:26]`. Any opcode other than 0x02, 0x04 and 0x05 moves `pc` to `pc` + 4 on an edge with no stall.
- R5: Opcode 0x04 (branch when equal) is taken when `ops_equal` is 1. A taken branch moves `pc` to `pc` + 4 + 4 × sign-extended `instr[15:0]`. When the branch is not taken, `pc` moves to `pc` + 4.
- R6: Opcode 0x05 (branch when not equal) is taken when `ops_equal` is 0 and uses the same target rule as R5. When `ops_equal` is 1 it is not taken and `pc` moves to `pc` + 4.
- R7: The branch offset is signed. A branch at 0x00400054 with immediate 0xFFFA lands on 0x00400040, and immediate 0x8000 steps back by 0x20000 bytes from `pc` + 4.
- R8: Opcode 0x02 (jump) moves `pc` to {`pc`[31:28], `instr[25:0]`, 2'b00}. The top four bits come from the jump's own address, not from `pc` + 4.
- R9: `ops_equal` has no effect on the next `pc` for jumps and for sequential opcodes.
- R10: `pc[1:0]` is 0 at every clock after the first reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset to the text start address |
| stall | input | 1 | Hold the program counter this cycle |
| instr | input | 32 | Instruction word fetched at `pc` |
| ops_equal | input | 1 | 1 when the two compared registers are equal |
| pc | output | 32 | Current program counter |
| pc_plus4 | output | 32 | Address of the following word |

## Verification
The embedded properties check several behaviours on every clock. They check the reset value, the hold under stall and the word alignment. They check the +4 step for sequential opcodes, the fall-through of untaken branches to `pc_plus4`, and the fact that a jump keeps the region bits of its own address. Only the bench scenarios can show that taken branch targets are numerically right for positive, negative and extreme immediates. The same holds for the choice of the current PC rather than PC+4 when a jump is made from the last word of a region, and for the irrelevance of the equality input for non-branch opcodes.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int ADDR_W   = 32;
  localparam int INSTR_W  = 32;
  localparam int OPC_W    = 6;
  localparam int IMM_W    = 16;
  localparam int JFIELD_W = 26;
  localparam int ALIGN_W  = 2;
  localparam int REGION_W = ADDR_W - JFIELD_W - ALIGN_W;
  localparam int SEXT_W   = ADDR_W - IMM_W - ALIGN_W;
  localparam int OPC_LSB  = INSTR_W - OPC_W;

  localparam logic [OPC_W-1:0] OPC_JUMP = 6'h02;
  localparam logic [OPC_W-1:0] OPC_BREQ = 6'h04;
  localparam logic [OPC_W-1:0] OPC_BRNE = 6'h05;

  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(1 << ALIGN_W);

  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [1:0] {
    FLOW_SEQ = 2'd0,
    FLOW_BEQ = 2'd1,
    FLOW_BNE = 2'd2,
    FLOW_JMP = 2'd3
  } flow_e;

  function automatic addr_t f_step(input addr_t cur);
    return cur + WORD_STEP;
  endfunction

  function automatic addr_t f_branch(input addr_t after, input logic [IMM_W-1:0] imm);
    addr_t ofs;
    ofs = {{SEXT_W{imm[IMM_W-1]}}, imm, {ALIGN_W{1'b0}}};
    return after + ofs;
  endfunction

  function automatic addr_t f_jump(input addr_t cur, input logic [JFIELD_W-1:0] fld);
    return {cur[ADDR_W-1 -: REGION_W], fld, {ALIGN_W{1'b0}}};
  endfunction

  function automatic addr_t f_align(input addr_t a);
    return {a[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
  endfunction
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output flow_e            kind
);
  always_comb begin
    unique case (opcode)
      OPC_JUMP: kind = FLOW_JMP;
      OPC_BREQ: kind = FLOW_BEQ;
      OPC_BRNE: kind = FLOW_BNE;
      default:  kind = FLOW_SEQ;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
(
  input  addr_t              cur_pc,
  input  logic [INSTR_W-1:0] instr,
  output addr_t              seq_addr,
  output addr_t              br_addr,
  output addr_t              jmp_addr
);
  logic [IMM_W-1:0]    imm_field;
  logic [JFIELD_W-1:0] jmp_field;

  assign imm_field = instr[IMM_W-1:0];
  assign jmp_field = instr[JFIELD_W-1:0];

  assign seq_addr = f_step(cur_pc);
  assign br_addr  = f_branch(seq_addr, imm_field);
  assign jmp_addr = f_jump(cur_pc, jmp_field);
endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
(
  input  flow_e kind,
  input  logic  ops_equal,
  input  addr_t seq_addr,
  input  addr_t br_addr,
  input  addr_t jmp_addr,
  output logic  take_branch,
  output addr_t next_addr
);
  addr_t raw_next;

  always_comb begin
    unique case (kind)
      FLOW_BEQ: take_branch = ops_equal;
      FLOW_BNE: take_branch = ~ops_equal;
      default:  take_branch = 1'b0;
    endcase
  end

  always_comb begin
    if (kind == FLOW_JMP)  raw_next = jmp_addr;
    else if (take_branch)  raw_next = br_addr;
    else                   raw_next = seq_addr;
  end

  assign next_addr = f_align(raw_next);
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0040_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        stall,
  input  logic [31:0] instr,
  input  logic        ops_equal,
  output logic [31:0] pc,
  output logic [31:0] pc_plus4
);
  localparam addr_t RESET_ALIGNED = f_align(RESET_PC);

  addr_t pc_q;
  addr_t seq_addr;
  addr_t br_addr;
  addr_t jmp_addr;
  addr_t next_addr;
  flow_e kind;
  logic  take_branch;
  logic  advance;

  npc_decode u_decode (
    .opcode (instr[INSTR_W-1:OPC_LSB]),
    .kind   (kind)
  );

  npc_target u_target (
    .cur_pc   (pc_q),
    .instr    (instr),
    .seq_addr (seq_addr),
    .br_addr  (br_addr),
    .jmp_addr (jmp_addr)
  );

  npc_select u_select (
    .kind        (kind),
    .ops_equal   (ops_equal),
    .seq_addr    (seq_addr),
    .br_addr     (br_addr),
    .jmp_addr    (jmp_addr),
    .take_branch (take_branch),
    .next_addr   (next_addr)
  );

  assign advance = ~rst & ~stall;

  always_ff @(posedge clk) begin
    if (rst)          pc_q <= RESET_ALIGNED;
    else if (advance) pc_q <= next_addr;
  end

  assign pc       = pc_q;
  assign pc_plus4 = seq_addr;

  // Checking: armed once a reset has been seen, so no property sees pre-reset X.
  logic armed;
  always_ff @(posedge clk) armed <= (armed === 1'b1) | rst;

  a_r1_reset_value: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    rst |=> pc == RESET_ALIGNED);

  a_r2_stall_hold: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    (!rst && stall) |=> $stable(pc));

  a_r4_seq_step: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    (advance && kind == FLOW_SEQ) |=> pc == $past(pc) + 32'd4);

  a_r5_r6_fall_through: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    (advance && (kind == FLOW_BEQ || kind == FLOW_BNE) && !take_branch)
      |=> pc == $past(pc_plus4));

  a_r8_region_kept: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    (advance && kind == FLOW_JMP) |=> pc[31:28] == $past(pc[31:28]));

  always @(negedge clk) begin
    if (armed === 1'b1)
      a_r10_aligned: assert (pc[1:0] == 2'b00);
  end
endmodule

// File: tb/test_npc_unit.sv
`timescale 1ns/1ps
module test_npc_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b0;
  logic        stall = 1'b0;
  logic [31:0] instr = 32'h0;
  logic        ops_equal = 1'b0;
  logic [31:0] pc;
  logic [31:0] pc_plus4;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit model_ok = 0;
  longint model_pc = 0;

  always #2 clk = ~clk;

  npc_unit i_npc_unit (
    .clk(clk), .rst(rst), .stall(stall), .instr(instr),
    .ops_equal(ops_equal), .pc(pc), .pc_plus4(pc_plus4)
  );

  function automatic logic [31:0] mk_i(int op, int imm);
    return (32'(op) << 26) | (32'd9 << 21) | (32'd10 << 16) | (32'(imm) & 32'hFFFF);
  endfunction

  function automatic logic [31:0] mk_j(int op, longint target);
    return (32'(op) << 26) | (32'(target / 4) & 32'h03FF_FFFF);
  endfunction

  task automatic check(string tag, logic [31:0] act, longint exp);
    checks++;
    if (act !== 32'(exp)) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, 32'(exp));
    end
  endtask

  task automatic apply(logic [31:0] ins, logic eq, logic stl, logic rs, string tag);
    int opc;
    int imm;
    @(negedge clk);
    instr = ins; ops_equal = eq; stall = stl; rst = rs;
    #0.5;
    if (model_ok) check({"R3 ", tag}, pc_plus4, (model_pc + 4) % 64'h1_0000_0000);
    opc = int'(ins >> 26);
    imm = int'($signed(ins[15:0]));
    if (rs) model_pc = 64'h0040_0000;
    else if (!stl) begin
      if (opc == 2)
        model_pc = (model_pc / 64'h1000_0000) * 64'h1000_0000 + longint'(ins & 32'h03FF_FFFF) * 4;
      else if ((opc == 4 && eq) || (opc == 5 && !eq))
        model_pc = (model_pc + 4 + 4 * longint'(imm)) & 64'hFFFF_FFFF;
      else
        model_pc = (model_pc + 4) % 64'h1_0000_0000;
    end
    if (rs) model_ok = 1;
    @(posedge clk);
    #1;
    if (model_ok) begin
      check(tag, pc, model_pc);
      check({"R10 ", tag}, {30'd0, pc[1:0]}, 0);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    apply(mk_j(2, 64'h0BAD_0000), 1, 1, 1, "R1 reset under stall");
    apply(mk_i(0, 0), 0, 0, 1, "R1 reset again");
    apply(mk_j(2, 64'h0000_1000), 1, 1, 0, "R2 stall holds jump");
    apply(mk_i(4, 16), 1, 1, 0, "R2 stall holds branch");
    apply(mk_i(0, 16), 1, 0, 0, "R4 R9 opcode 0 eq=1");
    apply(mk_i(8, 3), 0, 0, 0, "R4 opcode 0x08");
    apply(mk_i(6'h23, 4), 1, 0, 0, "R4 opcode 0x23");
    apply(mk_i(3, 5), 0, 0, 0, "R4 opcode 0x03");
    apply(mk_i(6, 7), 1, 0, 0, "R4 opcode 0x06");
    apply(mk_j(2, 64'h0040_0054), 0, 0, 0, "R8 R9 jump to 0x54");
    apply(mk_i(5, 16'hFFFA), 0, 0, 0, "R6 R7 bne back to 0x40");
    apply(mk_i(5, 16'h0020), 1, 0, 0, "R6 bne not taken");
    apply(mk_i(4, 16'h0010), 1, 0, 0, "R5 beq taken forward");
    apply(mk_i(4, 16'h0010), 0, 0, 0, "R5 beq not taken");
    apply(mk_i(4, 16'h7FFF), 1, 0, 0, "R5 beq max forward");
    apply(mk_i(4, 16'h8000), 1, 0, 0, "R7 beq most negative");
    apply(mk_j(2, 64'h0FFF_FFFC), 1, 0, 0, "R8 jump region top");
    apply(mk_i(5, 16'h0004), 0, 1, 0, "R2 stall at region top");
    apply(mk_j(2, 64'h0000_0000), 0, 0, 0, "R8 jump uses current pc region");
    apply(mk_i(4, 16'hFFFF), 1, 0, 0, "R5 R7 beq self loop");
    apply(mk_i(5, 16'h0003), 1, 0, 0, "R6 bne eq=1 falls through");
    apply(mk_i(1, 16'h0100), 0, 0, 0, "R4 R9 opcode 0x01 eq=0");
    apply(mk_i(4, 16'h0040), 1, 1, 1, "R1 reset beats branch");
    apply(mk_i(0, 0), 0, 0, 0, "R4 step after reset");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule